// File: doc/BRIEF.md
# Ping-Pong Matrix Bit Interleaver Address Generator

This block sequences a two-bank matrix bit interleaver. Coded bits are written into one bank in a load order, while the other bank, filled earlier, is read out in a different order. In the load order the row steps by a stride that shares no factor with the row count, and the column moves on once every row of it has been written. In the fetch order the reads walk diagonals: each read moves one row down and a fixed number of columns back, wrapping modulo the column count. Each new pass starts one column to the right of where the previous pass started.

The matrix shape comes from two configuration inputs. `cfgSlow` selects the lowest-rate variant, which uses fewer rows, a load stride of 7 and a fetch step of 7. `cfgLong` selects the long or the short depth. A third input, `cfgBypass`, turns the matrix off so that bits pass straight through. The banks swap only once the load bank is full and the fetch bank has been emptied. The swap is announced by a one-cycle pulse. The configuration is expected to change only while reset is held.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, all load and fetch row and column outputs are 0, `loadBank` is 0, `loadFull` is 0, `fetchEmpty` is 1, `blockDone` is 0 and `fetchBit` is 0.
- R2: With `cfgSlow`=0 the matrix has 40 rows. Each accepted load moves the load row by +9 modulo 40, starting at row 0 and column 0. When the next row would be 0 again, the column increments.
- R3: With `cfgSlow`=1 the load row steps by +7 modulo 20 when `cfgLong`=1, and modulo 10 when `cfgLong`=0. The column advances as in R2.
- R4: The column count is `COLS_STD_SHORT`/`COLS_STD_LONG` when `cfgSlow`=0 and `COLS_SLOW_SHORT`/`COLS_SLOW_LONG` when `cfgSlow`=1, for the short and long depth respectively. With `cfgSlow`=0, each accepted fetch moves to row+1 and column−17 modulo the column count. With the default long shape (40×24), the second and third fetches address (1,7) and (2,14).
- R5: After a fetch at the last row, the fetch row returns to 0 and the column becomes one more than the column used at the previous row-0 read.
- R6: With `cfgSlow`=1 the fetch column step is 7 instead of 17.
- R7: `loadFull` rises after rows×columns accepted loads. While it is high and no swap occurs, `loadStb` is ignored: the load address holds and the bank contents are not written.
- R8: `fetchEmpty` rises after rows×columns accepted fetches. While it is high, `fetchStb` is ignored.
- R9: `blockDone` is high for exactly the cycles in which `loadFull` and `fetchEmpty` are both 1. On the next clock edge `loadBank` toggles, `loadFull` and `fetchEmpty` clear, and all addresses return to 0.
- R10: A fetch reads the bank opposite `loadBank`. `fetchBit` presents the bit stored at the fetched row and column on the clock edge that accepts the fetch.
- R11: With `cfgBypass`=1, each `loadStb` copies `loadBit` to `fetchBit` on that edge. Addresses, flags and the bank contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSlow | input | 1 | Lowest-rate matrix variant |
| cfgLong | input | 1 | Long depth when 1, short when 0 |
| cfgBypass | input | 1 | Matrix bypass |
| loadStb | input | 1 | Write one coded bit |
| loadBit | input | 1 | Bit to write |
| fetchStb | input | 1 | Read one bit |
| loadRow | output | ROW_W | Row of the next load |
| loadCol | output | COL_W | Column of the next load |
| fetchRow | output | ROW_W | Row of the next fetch |
| fetchCol | output | COL_W | Column of the next fetch |
| loadBank | output | 1 | Bank being loaded; the other is fetched |
| loadFull | output | 1 | Load bank complete |
| fetchEmpty | output | 1 | Fetch bank exhausted |
| blockDone | output | 1 | Swap pulse |
| fetchBit | output | 1 | Fetched or bypassed bit |

## Verification
A wrong step in the load or fetch counters shows up on the address ports at the very next strobe. A diagonal that wraps badly goes unseen until the next row-0 restart, at most one pass of rows later. A flag or bank error would either swap the banks early, which moves `loadBank` one cycle after the fault, or stall them forever, which `blockDone` never rising exposes. Write-enable or bank-select faults only appear a whole block later, when the other bank is read back and `fetchBit` mismatches the pattern written at that row and column.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic passEn;
  } ilvStb_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl import ilv_pkg::*; #(
  parameter int ROWS_STD        = 40,
  parameter int ROWS_SLOW_LONG  = 20,
  parameter int ROWS_SLOW_SHORT = 10,
  parameter int STRIDE_STD      = 9,
  parameter int STRIDE_SLOW     = 7,
  parameter int STEP_STD        = 17,
  parameter int STEP_SLOW       = 7,
  parameter int COLS_STD_SHORT  = 18,
  parameter int COLS_STD_LONG   = 24,
  parameter int COLS_SLOW_SHORT = 9,
  parameter int COLS_SLOW_LONG  = 12,
  parameter int ROW_W           = 6,
  parameter int COL_W           = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSlow,
  input  logic             cfgLong,
  input  logic             cfgBypass,
  input  logic             loadStb,
  input  logic             fetchStb,
  output logic [ROW_W-1:0] loadRow,
  output logic [COL_W-1:0] loadCol,
  output logic [ROW_W-1:0] fetchRow,
  output logic [COL_W-1:0] fetchCol,
  output logic             loadBank,
  output logic             loadFull,
  output logic             fetchEmpty,
  output logic             blockDone,
  output ilvStb_t          stb
);
  logic [ROW_W-1:0] rows, stride, loadRowNext;
  logic [COL_W-1:0] cols, step, fetchColNext, fetchBase;
  logic rowWrap, loadLast, fetchRowLast, fetchLast, swap;

  always_comb begin
    unique case ({cfgSlow, cfgLong})
      2'b00:   begin rows = ROW_W'(ROWS_STD);        cols = COL_W'(COLS_STD_SHORT);  end
      2'b01:   begin rows = ROW_W'(ROWS_STD);        cols = COL_W'(COLS_STD_LONG);   end
      2'b10:   begin rows = ROW_W'(ROWS_SLOW_SHORT); cols = COL_W'(COLS_SLOW_SHORT); end
      default: begin rows = ROW_W'(ROWS_SLOW_LONG);  cols = COL_W'(COLS_SLOW_LONG);  end
    endcase
    stride = cfgSlow ? ROW_W'(STRIDE_SLOW) : ROW_W'(STRIDE_STD);
    step   = cfgSlow ? COL_W'(STEP_SLOW)   : COL_W'(STEP_STD);
  end

  // modular steps computed without overflow
  assign loadRowNext  = (loadRow >= rows - stride) ? loadRow - (rows - stride) : loadRow + stride;
  assign rowWrap      = (loadRowNext == '0);
  assign loadLast     = rowWrap && (loadCol == cols - 1'b1);
  assign fetchColNext = (fetchCol >= step) ? fetchCol - step : fetchCol + (cols - step);
  assign fetchRowLast = (fetchRow == rows - 1'b1);
  assign fetchLast    = fetchRowLast && (fetchBase == cols - 1'b1);
  assign swap         = loadFull && fetchEmpty;
  assign blockDone    = swap;

  assign stb.wrEn   = loadStb && !loadFull && !cfgBypass && !swap;
  assign stb.rdEn   = fetchStb && !fetchEmpty && !cfgBypass && !swap;
  assign stb.passEn = loadStb && cfgBypass;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadRow <= '0; loadCol <= '0;
      fetchRow <= '0; fetchCol <= '0; fetchBase <= '0;
      loadBank <= 1'b0; loadFull <= 1'b0; fetchEmpty <= 1'b1;
    end else if (swap) begin
      loadRow <= '0; loadCol <= '0;
      fetchRow <= '0; fetchCol <= '0; fetchBase <= '0;
      loadBank <= ~loadBank; loadFull <= 1'b0; fetchEmpty <= 1'b0;
    end else begin
      if (stb.wrEn) begin
        if (loadLast) loadFull <= 1'b1;
        else begin
          loadRow <= loadRowNext;
          if (rowWrap) loadCol <= loadCol + 1'b1;
        end
      end
      if (stb.rdEn) begin
        if (fetchLast) fetchEmpty <= 1'b1;
        else if (fetchRowLast) begin
          fetchRow  <= '0;
          fetchBase <= fetchBase + 1'b1;
          fetchCol  <= fetchBase + 1'b1;
        end else begin
          fetchRow <= fetchRow + 1'b1;
          fetchCol <= fetchColNext;
        end
      end
    end
  end

  AST_LOAD_ROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    loadRow < rows); // R2
  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (loadFull && !swap) |=> ($stable(loadRow) && $stable(loadCol))); // R7
  AST_EMPTY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEmpty && !swap) |=> ($stable(fetchRow) && $stable(fetchCol))); // R8
  AST_FETCH_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && !fetchRowLast) |=> (fetchRow == $past(fetchRow) + 1'b1)); // R4
  AST_PASS_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && fetchRowLast && !fetchLast) |=> (fetchRow == '0 && fetchCol == $past(fetchBase) + 1'b1)); // R5
  AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    swap |=> (loadBank != $past(loadBank) && !loadFull && !fetchEmpty)); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !swap |=> $stable(loadBank)); // R9
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath import ilv_pkg::*; #(
  parameter int ROWS_MAX = 40,
  parameter int COLS_MAX = 24,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ilvStb_t          stb,
  input  logic             loadBit,
  input  logic             loadBank,
  input  logic [ROW_W-1:0] loadRow,
  input  logic [COL_W-1:0] loadCol,
  input  logic [ROW_W-1:0] fetchRow,
  input  logic [COL_W-1:0] fetchCol,
  output logic             fetchBit
);
  localparam int BANK_SZ = ROWS_MAX * COLS_MAX;
  localparam int DEPTH   = 2 * BANK_SZ;
  localparam int AW      = $clog2(DEPTH);

  logic memBits [DEPTH];
  logic [AW-1:0] wrAddr, rdAddr;
  logic fetchBank;

  assign fetchBank = ~loadBank;
  assign wrAddr = (loadBank ? AW'(BANK_SZ) : AW'(0)) + AW'(loadRow) * AW'(COLS_MAX) + AW'(loadCol);
  assign rdAddr = (fetchBank ? AW'(BANK_SZ) : AW'(0)) + AW'(fetchRow) * AW'(COLS_MAX) + AW'(fetchCol);

  always_ff @(posedge clk) begin
    if (stb.wrEn) memBits[wrAddr] <= loadBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           fetchBit <= 1'b0;
    else if (stb.rdEn)   fetchBit <= memBits[rdAddr];
    else if (stb.passEn) fetchBit <= loadBit;
  end

  AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    stb.passEn |=> (fetchBit == $past(loadBit))); // R11
  AST_NO_DUAL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.passEn && (stb.wrEn || stb.rdEn))); // R11
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen import ilv_pkg::*; #(
  parameter int ROWS_STD        = 40,
  parameter int ROWS_SLOW_LONG  = 20,
  parameter int ROWS_SLOW_SHORT = 10,
  parameter int STRIDE_STD      = 9,
  parameter int STRIDE_SLOW     = 7,
  parameter int STEP_STD        = 17,
  parameter int STEP_SLOW       = 7,
  parameter int COLS_STD_SHORT  = 18,
  parameter int COLS_STD_LONG   = 24,
  parameter int COLS_SLOW_SHORT = 9,
  parameter int COLS_SLOW_LONG  = 12,
  localparam int COLS_A   = (COLS_STD_SHORT > COLS_STD_LONG) ? COLS_STD_SHORT : COLS_STD_LONG,
  localparam int COLS_B   = (COLS_SLOW_SHORT > COLS_SLOW_LONG) ? COLS_SLOW_SHORT : COLS_SLOW_LONG,
  localparam int COLS_MAX = (COLS_A > COLS_B) ? COLS_A : COLS_B,
  localparam int ROW_W    = $clog2(ROWS_STD + 1),
  localparam int COL_W    = $clog2(COLS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSlow,
  input  logic             cfgLong,
  input  logic             cfgBypass,
  input  logic             loadStb,
  input  logic             loadBit,
  input  logic             fetchStb,
  output logic [ROW_W-1:0] loadRow,
  output logic [COL_W-1:0] loadCol,
  output logic [ROW_W-1:0] fetchRow,
  output logic [COL_W-1:0] fetchCol,
  output logic             loadBank,
  output logic             loadFull,
  output logic             fetchEmpty,
  output logic             blockDone,
  output logic             fetchBit
);
  ilvStb_t stb;

  ilv_ctrl #(
    .ROWS_STD(ROWS_STD), .ROWS_SLOW_LONG(ROWS_SLOW_LONG), .ROWS_SLOW_SHORT(ROWS_SLOW_SHORT),
    .STRIDE_STD(STRIDE_STD), .STRIDE_SLOW(STRIDE_SLOW),
    .STEP_STD(STEP_STD), .STEP_SLOW(STEP_SLOW),
    .COLS_STD_SHORT(COLS_STD_SHORT), .COLS_STD_LONG(COLS_STD_LONG),
    .COLS_SLOW_SHORT(COLS_SLOW_SHORT), .COLS_SLOW_LONG(COLS_SLOW_LONG),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgSlow(cfgSlow), .cfgLong(cfgLong), .cfgBypass(cfgBypass),
    .loadStb(loadStb), .fetchStb(fetchStb),
    .loadRow(loadRow), .loadCol(loadCol), .fetchRow(fetchRow), .fetchCol(fetchCol),
    .loadBank(loadBank), .loadFull(loadFull), .fetchEmpty(fetchEmpty),
    .blockDone(blockDone), .stb(stb)
  );

  ilv_datapath #(
    .ROWS_MAX(ROWS_STD), .COLS_MAX(COLS_MAX), .ROW_W(ROW_W), .COL_W(COL_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .loadBit(loadBit), .loadBank(loadBank),
    .loadRow(loadRow), .loadCol(loadCol), .fetchRow(fetchRow), .fetchCol(fetchCol),
    .fetchBit(fetchBit)
  );
endmodule

// File: tb/test_ilv_addr_gen.sv
module test_ilv_addr_gen;
  localparam int CS_STD = 18, CL_STD = 24, CS_SLOW = 9, CL_SLOW = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgSlow = 1'b0, cfgLong = 1'b0, cfgBypass = 1'b0;
  logic loadStb = 1'b0, loadBit = 1'b0, fetchStb = 1'b0;
  logic [5:0] loadRow, fetchRow;
  logic [4:0] loadCol, fetchCol;
  logic loadBank, loadFull, fetchEmpty, blockDone, fetchBit;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ilv_addr_gen #(
    .COLS_STD_SHORT(CS_STD), .COLS_STD_LONG(CL_STD),
    .COLS_SLOW_SHORT(CS_SLOW), .COLS_SLOW_LONG(CL_SLOW)
  ) i_ilv_addr_gen (
    .clk(clk), .rstN(rstN), .cfgSlow(cfgSlow), .cfgLong(cfgLong), .cfgBypass(cfgBypass),
    .loadStb(loadStb), .loadBit(loadBit), .fetchStb(fetchStb),
    .loadRow(loadRow), .loadCol(loadCol), .fetchRow(fetchRow), .fetchCol(fetchCol),
    .loadBank(loadBank), .loadFull(loadFull), .fetchEmpty(fetchEmpty),
    .blockDone(blockDone), .fetchBit(fetchBit)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rowsOf(bit s, bit l);
    return s ? (l ? 20 : 10) : 40;
  endfunction
  function automatic int colsOf(bit s, bit l);
    return s ? (l ? CL_SLOW : CS_SLOW) : (l ? CL_STD : CS_STD);
  endfunction
  function automatic bit pat(int r, int c, int seed);
    return ((r * 3 + c * 5 + seed) % 7) < 3;
  endfunction

  task automatic doReset(bit s, bit l, bit b);
    @(negedge clk);
    rstN = 1'b0; cfgSlow = s; cfgLong = l; cfgBypass = b;
    loadStb = 1'b0; fetchStb = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // R1
  task automatic testReset();
    doReset(1'b0, 1'b1, 1'b0);
    check("R1 loadRow", loadRow, 0);   check("R1 loadCol", loadCol, 0);
    check("R1 fetchRow", fetchRow, 0); check("R1 fetchCol", fetchCol, 0);
    check("R1 loadBank", loadBank, 0); check("R1 loadFull", loadFull, 0);
    check("R1 fetchEmpty", fetchEmpty, 1); check("R1 blockDone", blockDone, 0);
    check("R1 fetchBit", fetchBit, 0);
  endtask

  // load one full block, checking the load order (R2/R3/R7)
  task automatic loadBlock(bit s, bit l, int seed);
    int rows = rowsOf(s, l), cols = colsOf(s, l);
    int stride = s ? 7 : 9;
    int r = 0, c = 0;
    for (int k = 0; k < rows * cols; k++) begin
      check(s ? "R3 loadRow" : "R2 loadRow", loadRow, r);
      check(s ? "R3 loadCol" : "R2 loadCol", loadCol, c);
      check("R7 loadFull low", loadFull, 0);
      loadStb = 1'b1; loadBit = pat(r, c, seed);
      @(negedge clk);
      loadStb = 1'b0;
      r = (r + stride) % rows;
      if (r == 0 && k != rows * cols - 1) c++;
    end
    check("R7 loadFull", loadFull, 1);
  endtask

  // fetch one full block, checking the diagonal order and data (R4/R5/R6/R8/R10)
  task automatic fetchBlock(bit s, bit l, int seed);
    int rows = rowsOf(s, l), cols = colsOf(s, l);
    int stepC = s ? 7 : 17;
    int r = 0, c = 0, base = 0;
    for (int k = 0; k < rows * cols; k++) begin
      check(s ? "R6 fetchRow" : "R4 fetchRow", fetchRow, r);
      check(s ? "R6 fetchCol" : (r == 0 ? "R5 fetchCol" : "R4 fetchCol"), fetchCol, c);
      check("R8 fetchEmpty low", fetchEmpty, 0);
      fetchStb = 1'b1;
      @(negedge clk);
      fetchStb = 1'b0;
      check("R10 fetchBit", fetchBit, pat(r, c, seed));
      if (r == rows - 1) begin r = 0; base++; c = base; end
      else begin r++; c = (c - stepC + cols) % cols; end
    end
    check("R8 fetchEmpty", fetchEmpty, 1);
  endtask

  task automatic testFlow(bit s, bit l, int seed);
    int rows = rowsOf(s, l), cols = colsOf(s, l);
    logic [5:0] holdR; logic [4:0] holdC;
    doReset(s, l, 1'b0);
    loadBlock(s, l, seed);
    check("R9 blockDone first", blockDone, 1);
    @(negedge clk);
    check("R9 bank after swap", loadBank, 1);
    check("R9 blockDone cleared", blockDone, 0);
    check("R9 loadFull cleared", loadFull, 0);
    check("R9 fetchEmpty cleared", fetchEmpty, 0);
    loadBlock(s, l, seed + 1);
    check("R9 no swap while fetch pending", blockDone, 0);
    holdR = loadRow; holdC = loadCol;
    loadStb = 1'b1; loadBit = ~pat(rows - 1 - ((rows - 1) % 1), cols - 1, seed + 1);
    @(negedge clk);
    loadStb = 1'b0;
    check("R7 ignored load row", loadRow, holdR);
    check("R7 ignored load col", loadCol, holdC);
    check("R7 bank held", loadBank, 1);
    fetchBlock(s, l, seed);
    check("R9 blockDone second", blockDone, 1);
    fetchStb = 1'b1;
    @(negedge clk);
    fetchStb = 1'b0;
    check("R9 bank back", loadBank, 0);
    check("R8 fetch during swap ignored", fetchRow, 0);
    fetchBlock(s, l, seed + 1);
    check("R9 no swap while load pending", blockDone, 0);
    fetchStb = 1'b1;
    @(negedge clk);
    fetchStb = 1'b0;
    check("R8 ignored fetch row", fetchRow, rows - 1);
    check("R8 ignored fetch empty", fetchEmpty, 1);
  endtask

  // R11
  task automatic testBypass();
    doReset(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      loadStb = 1'b1; loadBit = k[0] ^ k[1]; fetchStb = k[0];
      @(negedge clk);
      loadStb = 1'b0; fetchStb = 1'b0;
      check("R11 fetchBit echo", fetchBit, k[0] ^ k[1]);
      check("R11 loadRow held", loadRow, 0);
      check("R11 loadCol held", loadCol, 0);
      check("R11 fetchRow held", fetchRow, 0);
      check("R11 loadFull held", loadFull, 0);
    end
  endtask

  initial begin
    testReset();
    testFlow(1'b0, 1'b1, 0);   // R4: 40x24, fetches 2 and 3 at (1,7) and (2,14)
    testFlow(1'b0, 1'b0, 2);
    testFlow(1'b1, 1'b1, 4);
    testFlow(1'b1, 1'b0, 6);
    testBypass();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule